// File: doc/BRIEF.md
# HDB3 Receive Line Decoder

This block sits behind clock recovery on the receive side of a bipolar line interface. Each bit period it takes one sample of two rails on the rising edge of the recovered clock. One rail marks a positive pulse and the other marks a negative pulse. The block removes the two legal four-zero substitution codes and drives plain NRZ data, which changes on the falling edge of the same clock.

Three other functions run alongside the decoder. A one-bit-wide error pulse flags any line-code fault that is not a legal substitution. An active-low alarm reports a long run of bit periods with no pulse. An active-low alarm-indication input forces the data output to all ones while the monitors keep working.

The decode path holds four bits. When a violation pulse arrives, the bit three positions earlier may be the balancing pulse of a B00V code, and it is still inside the block, so it can be erased before it leaves.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: A B00V or 000V substitution (V is a pulse of the same polarity as the previous pulse, preceded by at least two empty bits) decodes to four zeros: both the V and the bit three positions before it leave as 0, and no error pulse is raised.
- R2: A bit sampled on rising edge s appears on `nrz_o` from the falling edge that follows rising edge s+3. A single-rail pulse that is not part of a substitution decodes to 1, and an empty bit decodes to 0.
- R3: A fault in the bit sampled on rising edge s drives `cv_o` high for exactly the clock period that follows rising edge s+3, and `cv_o` stays low when there is no fault.
- R4: A substitution V whose polarity equals that of the previous substitution V is a fault. It is still decoded as zeros. The first V after reset is exempt.
- R5: A pulse with the same polarity as the previous pulse that is preceded by fewer than two empty bits is a fault, and it decodes to 1.
- R6: The fourth consecutive empty bit of a run is a fault, raised once per run.
- R7: Both rails high in one bit is a fault. The bit decodes to 1, counts as a pulse, and leaves the stored polarity unchanged.
- R8: `los_n_o` goes low from the rising edge that samples the LOS_LIM-th consecutive bit with neither rail high. LOS_LIM is a parameter, legal range 20 to 32, default 32.
- R9: `los_n_o` returns high from the rising edge that samples any bit with either rail high.
- R10: While `ais_n_i` is low at a falling edge, `nrz_o` is driven to 1 at that edge. `cv_o` and `los_n_o` are unaffected.
- R11: Reset gives `nrz_o`=0, `cv_o`=0 and `los_n_o`=1. The stored last-pulse polarity is negative, so a negative first pulse is treated as a violation pulse with no empty bits before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock; rails sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_i | input | 1 | Positive-pulse rail |
| neg_i | input | 1 | Negative-pulse rail |
| ais_n_i | input | 1 | Active-low all-ones override for the data output |
| nrz_o | output | 1 | Decoded NRZ data, updated on the falling edge |
| cv_o | output | 1 | One-bit-wide line-code fault pulse |
| los_n_o | output | 1 | Active-low loss-of-signal alarm |

## Verification
The pulse that ends a long empty run can itself be a fault, for example a bit with both rails high. In that case the alarm clears and a fault is detected in the same bit. The bench provokes this by letting the alarm assert over 35 empty bits and then sending a both-rails bit. It expects `los_n_o` to rise on that edge and `cv_o` to pulse three edges later. A second overlap is the all-ones override running while faults are injected. Every clock, a behavioural reference built from queues predicts the data, the fault pulse and the alarm, and the bench compares all three.

// File: rtl/hdb3rx_pkg.sv
package hdb3rx_pkg;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } pol_e;

    // polarity memory of the violation classifier
    typedef struct packed {
        pol_e last_mark;
        pol_e last_v;
        logic v_seen;
    } vdet_st_t;

endpackage

// File: rtl/hdb3rx_run.sv
module hdb3rx_run #(
    parameter int LOS_LIM = 32,
    localparam int CW = $clog2(LOS_LIM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pulse_i,
    output logic [CW-1:0] run_o,
    output logic          quad_o,
    output logic          los_n_o
);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          los_n;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pulse_i) begin
            st_d.run = '0;
        end else if (st_q.run != CW'(LOS_LIM)) begin
            st_d.run = st_q.run + 1'b1;
        end
        st_d.los_n = (st_d.run != CW'(LOS_LIM));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: '0, los_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o   = st_q.run;
    assign quad_o  = !pulse_i && (st_q.run == CW'(3));
    assign los_n_o = st_q.los_n;

    // R9: any pulse clears the alarm on the next edge
    a_r9_los_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> los_n_o);

    // R8: alarm can only drop after an empty bit
    a_r8_los_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los_n_o) |-> $past(!pulse_i));

endmodule

// File: rtl/hdb3rx_vdet.sv
module hdb3rx_vdet
    import hdb3rx_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pos_i,
    input  logic          neg_i,
    input  logic [CW-1:0] run_i,
    output logic          mark_o,
    output logic          sub_o,
    output logic          err_o
);

    vdet_st_t st_d, st_q;
    logic     both, single, is_v, pat_ok, sub, parity_bad;
    pol_e     pol;

    always_comb begin
        both       = pos_i & neg_i;
        single     = pos_i ^ neg_i;
        pol        = pos_i ? POL_POS : POL_NEG;
        is_v       = single && (pol == st_q.last_mark);
        pat_ok     = run_i >= CW'(2);
        sub        = is_v && pat_ok;
        parity_bad = sub && st_q.v_seen && (pol == st_q.last_v);

        st_d = st_q;
        if (single) begin
            st_d.last_mark = pol;
        end
        if (sub) begin
            st_d.last_v = pol;
            st_d.v_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{last_mark: POL_NEG, last_v: POL_NEG, v_seen: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sub_o  = sub;
    assign mark_o = (pos_i | neg_i) && !sub;
    assign err_o  = both | (is_v && !pat_ok) | parity_bad;

endmodule

// File: rtl/hdb3rx_dline.sv
module hdb3rx_dline #(
    parameter int DEPTH  = 4,
    parameter int CV_LAT = 3,
    localparam int CLR_POS = DEPTH - 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic clr_i,
    input  logic err_i,
    output logic bit_o,
    output logic cv_o
);

    typedef struct packed {
        logic [DEPTH-1:0] sr;
        logic [CV_LAT:0]  ep;
    } dl_st_t;

    dl_st_t st_d, st_q;

    always_comb begin
        st_d.sr[0] = bit_i;
        for (int i = 1; i < DEPTH; i++) begin
            if (i - 1 == CLR_POS) begin
                st_d.sr[i] = st_q.sr[i-1] & ~clr_i;
            end else begin
                st_d.sr[i] = st_q.sr[i-1];
            end
        end
        st_d.ep = {st_q.ep[CV_LAT-1:0], err_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.sr[DEPTH-1];
    assign cv_o  = st_q.ep[CV_LAT];

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder #(
    parameter int LOS_LIM = 32,
    localparam int CW = $clog2(LOS_LIM + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    input  logic ais_n_i,
    output logic nrz_o,
    output logic cv_o,
    output logic los_n_o
);

    logic [CW-1:0] run;
    logic          quad, mark, sub, code_err, dl_bit;
    logic          nrz_d, nrz_q;

    hdb3rx_run #(.LOS_LIM(LOS_LIM)) run_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pos_i | neg_i),
        .run_o   (run),
        .quad_o  (quad),
        .los_n_o (los_n_o)
    );

    hdb3rx_vdet #(.CW(CW)) vdet_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pos_i  (pos_i),
        .neg_i  (neg_i),
        .run_i  (run),
        .mark_o (mark),
        .sub_o  (sub),
        .err_o  (code_err)
    );

    hdb3rx_dline #(.DEPTH(4), .CV_LAT(3)) dline_i (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (mark),
        .clr_i (sub),
        .err_i (code_err | quad),
        .bit_o (dl_bit),
        .cv_o  (cv_o)
    );

    always_comb begin
        nrz_d = ais_n_i ? dl_bit : 1'b1;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nrz_q <= 1'b0;
        end else begin
            nrz_q <= nrz_d;
        end
    end

    assign nrz_o = nrz_q;

    // R7: both rails in one bit yields a fault pulse four edges later
    a_r7_both_rails_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i && neg_i) |-> ##4 cv_o);

    // R6: completing four empty bits yields a fault pulse
    a_r6_quad_cv: assert property (@(posedge clk) disable iff (!rst_n)
        quad |-> ##4 cv_o);

    // R10: override low at a falling edge forces ones
    a_r10_ais_ones: assert property (@(negedge clk) disable iff (!rst_n)
        !ais_n_i |=> nrz_o);

endmodule

// File: tb/hdb3_rx_decoder_tb_top.sv
module hdb3_rx_decoder_tb_top;

    localparam int LIM = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_i = 1'b0;
    logic neg_i = 1'b0;
    logic ais_n_i = 1'b1;
    logic nrz_o, cv_o, los_n_o;

    always #4 clk = ~clk;

    hdb3_rx_decoder #(.LOS_LIM(LIM)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_i   (pos_i),
        .neg_i   (neg_i),
        .ais_n_i (ais_n_i),
        .nrz_o   (nrz_o),
        .cv_o    (cv_o),
        .los_n_o (los_n_o)
    );

    int    checks = 0;
    int    fails = 0;
    string req = "R11";

    // reference model state
    int zrun = 0;
    bit lastpol = 1'b0;
    bit lastv = 1'b0;
    bit vseen = 1'b0;
    bit dq[$];
    bit eq[$];
    // encoder state
    int encpol = -1;
    int nb = 0;

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%b exp=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model(bit p, bit n);
        bit anyp, err, dbit, pol;
        bit e_nrz, e_cv, e_los;
        anyp = p | n;
        err  = 1'b0;
        dbit = anyp;
        pol  = p;
        if (p && n) begin
            err = 1'b1;
        end else if (anyp) begin
            if (pol == lastpol) begin
                if (zrun >= 2) begin
                    dbit = 1'b0;
                    if (dq.size() >= 3) dq[dq.size()-3] = 1'b0;
                    if (vseen && pol == lastv) err = 1'b1;
                    lastv = pol;
                    vseen = 1'b1;
                end else begin
                    err = 1'b1;
                end
            end
            lastpol = pol;
        end
        if (anyp) zrun = 0;
        else if (zrun < LIM) zrun++;
        if (!anyp && zrun == 4) err = 1'b1;
        dq.push_back(dbit);
        eq.push_back(err);
        e_cv  = (eq.size() >= 4) ? eq[eq.size()-4] : 1'b0;
        e_nrz = (dq.size() >= 4) ? dq[dq.size()-4] : 1'b0;
        if (!ais_n_i) e_nrz = 1'b1;
        e_los = !(zrun >= LIM);
        chk("nrz_o", nrz_o, e_nrz);
        chk("cv_o", cv_o, e_cv);
        chk("los_n_o", los_n_o, e_los);
        while (dq.size() > 8) void'(dq.pop_front());
        while (eq.size() > 8) void'(eq.pop_front());
    endtask

    task automatic cyc(bit p, bit n);
        pos_i = p;
        neg_i = n;
        @(posedge clk);
        #6;
        model(p, n);
    endtask

    task automatic line(int s);
        cyc(s > 0, s < 0);
        if (s != 0) encpol = s;
    endtask

    task automatic both_rails();
        cyc(1'b1, 1'b1);
    endtask

    task automatic send(bit d[$]);
        int i = 0;
        while (i < d.size()) begin
            if (i + 3 < d.size() && !d[i] && !d[i+1] && !d[i+2] && !d[i+3]) begin
                if (nb % 2 == 1) begin
                    line(0); line(0); line(0); line(encpol);
                end else begin
                    int b = -encpol;
                    line(b); line(0); line(0); line(b);
                end
                nb = 0;
                i += 4;
            end else if (d[i]) begin
                line(-encpol);
                nb++;
                i++;
            end else begin
                line(0);
                i++;
            end
        end
    endtask

    task automatic send_rand(int n);
        bit d[$];
        for (int k = 0; k < n; k++) d.push_back(1'($urandom_range(0, 1)));
        send(d);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit d[$];
        // R11: reset values
        repeat (3) @(posedge clk);
        #6;
        req = "R11";
        chk("nrz_o reset", nrz_o, 1'b0);
        chk("cv_o reset", cv_o, 1'b0);
        chk("los_n_o reset", los_n_o, 1'b1);
        rst_n = 1'b1;
        // R11: a negative first pulse is a bare violation
        line(-1);
        line(0); line(1); line(0); line(-1);

        req = "R2";
        send_rand(80);
        d = '{1,1,1,1,0,1,0,1,1,0,0,1};
        send(d);

        req = "R1";
        d = '{};
        for (int k = 0; k < 32; k++) d.push_back(1'b0);
        send(d);
        d = '{1,0,0,0,0,1,1,0,0,0,0,0,0,0,0,1,0,0,0,0,1};
        send(d);

        req = "R4";
        line(1); line(0); line(0); line(0); line(1);
        line(0); line(0); line(0); line(1);
        line(-1); line(0); line(0); line(-1);
        line(1); line(0); line(0); line(1);
        line(1); line(0); line(0); line(1);

        req = "R5";
        line(-1); line(-1); line(1); line(0); line(1); line(-1);

        req = "R6";
        line(0); line(0); line(0); line(0); line(0); line(0); line(1);
        line(0); line(0); line(0); line(0); line(-1);

        req = "R7";
        both_rails(); both_rails(); line(1); both_rails(); line(-1);
        send_rand(16);

        req = "R8";
        for (int k = 0; k < 40; k++) line(0);
        req = "R9";
        line(1); line(0); line(-1);
        req = "R8";
        for (int k = 0; k < LIM - 1; k++) line(0);
        line(0);
        req = "R9";
        for (int k = 0; k < 3; k++) line(0);
        // alarm clear and fault in the same bit
        both_rails();
        line(0); line(1); line(0); line(0); line(0);

        req = "R10";
        ais_n_i = 1'b0;
        send_rand(30);
        both_rails();
        for (int k = 0; k < 36; k++) line(0);
        line(1);
        ais_n_i = 1'b1;
        send_rand(20);

        req = "R3";
        for (int k = 0; k < 10; k++) begin
            send_rand(12);
            both_rails();
        end
        for (int k = 0; k < 6; k++) line(0);

        finish_run();
    end

endmodule